// File: doc/BRIEF.md
# BCD Time-of-Day Counter

This block keeps the time of day as three packed-BCD registers (seconds, minutes, hours in 24-hour form). A binary prescaler divides a 32.768 kHz clock-enable input down to a single-cycle 1 Hz pulse. That pulse steps the second register, and carries ripple through minutes and hours. When the hour rolls past 23, a one-cycle day-carry pulse is raised for an external calendar.

A host reaches the three registers through a plain address/data port, at 10h, 11h and 12h. While the host holds its access window open, the registers stay frozen, so a multi-byte read sees one consistent time. A 1 Hz pulse that falls inside the window is remembered and applied at the first clock edge after the window closes. A halt input stops counting and holds the divider at zero, so timekeeping restarts on the falling edge of the halt. Writing the second register restarts the sub-second divider. The value 60 is accepted there as a leap second.

Top module: `rtc_time_core`

## Requirements
- R1: After reset the second, minute and hour registers read 00h and `day_carry_o` is low.
- R2: With `stop_i` low and no access window open, the second register advances once per 2^DIV_W cycles in which `tick_32k_i` is high. Cycles with `tick_32k_i` low do not count.
- R3: The second register counts 00 to 59 in packed BCD (tens in bits 6:4, units in bits 3:0). On the step from 59 it becomes 00 and adds one to the minute register.
- R4: The minute register counts 00 to 59 in BCD and wraps to 00 with a carry into the hour register. The hour register counts 00 to 23 in BCD and wraps to 00.
- R5: When the hour wraps from 23 to 00, `day_carry_o` is high for exactly the one cycle in which the hour first reads 00.
- R6: While `stop_i` is high, no register advances and the divider is held at zero. After `stop_i` falls, the first advance comes after a full 2^DIV_W enable pulses.
- R7: A write to the second register clears the divider. The next advance comes after a full 2^DIV_W enable pulses counted from the write.
- R8: The second register accepts 60h. On the next 1 Hz step it becomes 00 and carries into the minute register.
- R9: While `acc_open_i` is high, the time registers do not change except by host writes. A 1 Hz step that occurs inside the window is applied at the first clock edge with `acc_open_i` low.
- R10: Addresses 10h, 11h and 12h select second, minute and hour. Any other address reads 00h, and writes to it change nothing.
- R11: Unused bits are masked on write and read as zero: bit 7 of the second and minute registers, and bits 7:6 of the hour register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_32k_i | input | 1 | 32.768 kHz clock enable, one cycle per pulse |
| stop_i | input | 1 | Halt counting and hold the divider at zero |
| acc_open_i | input | 1 | Host access window; freezes the time registers |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| day_carry_o | output | 1 | One-cycle pulse on the hour wrap 23 to 00 |

## Verification
Two functions can meet in the same cycle: the 1 Hz step and the freeze of the host window. The bench opens the window, starts counting so that a step lands inside the window, and then closes it. It expects the frozen value during the window and a single deferred increment at the first edge after the window closes. A second pairing is a seconds write landing mid-second on a running counter. There the bench requires the write to win and the divider to restart, and it checks the exact cycle of the next advance. A behavioural reference model tracks every cycle, and each cycle it compares the selected register and the day-carry output.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] SEC_ADDR  = 8'h10;
  localparam logic [7:0] MIN_ADDR  = 8'h11;
  localparam logic [7:0] HOUR_ADDR = 8'h12;
  localparam logic [7:0] LEAP_SEC  = 8'h60;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return v + 8'h01;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hold_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (hold_i || clr_i) cnt_q <= '0;
    else if (en_i)            cnt_q <= cnt_q + 1'b1;
  end

  // last stage wraps: one pulse per 2^DIV_W enables
  assign tick_o = en_i && !hold_i && !clr_i && (&cnt_q);
endmodule

// File: rtl/rtc_bcd_reg.sv
module rtc_bcd_reg #(
  parameter logic [7:0] LIMIT = 8'h59,
  parameter logic [7:0] MASK  = 8'h7F,
  parameter bit         LEAP  = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  import rtc_pkg::*;

  logic [7:0] val_q;
  logic       wrap;

  generate
    if (LEAP) begin : g_leap
      assign wrap = (val_q == LIMIT) || (val_q == LEAP_SEC);
    end else begin : g_plain
      assign wrap = (val_q == LIMIT);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= '0;
    else if (we_i)  val_q <= wdata_i & MASK;
    else if (inc_i) val_q <= wrap ? 8'h00 : bcd_inc(val_q);
  end

  assign val_o   = val_q;
  assign carry_o = inc_i && wrap;
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int DIV_W  = 15,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_32k_i,
  input  logic              stop_i,
  input  logic              acc_open_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              day_carry_o
);
  import rtc_pkg::*;

  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(SEC_ADDR);
  localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(MIN_ADDR);
  localparam logic [ADDR_W-1:0] A_HOUR = ADDR_W'(HOUR_ADDR);

  logic sec_sel, min_sel, hour_sel;
  logic sec_wr, min_wr, hour_wr;
  logic tick_1hz, pend_q, sec_adv;
  logic sec_c, min_c, hour_c;
  logic [7:0] sec_q, min_q, hour_q;
  logic day_carry_q;

  assign sec_sel  = (addr_i == A_SEC);
  assign min_sel  = (addr_i == A_MIN);
  assign hour_sel = (addr_i == A_HOUR);
  assign sec_wr   = wr_en_i && sec_sel;
  assign min_wr   = wr_en_i && min_sel;
  assign hour_wr  = wr_en_i && hour_sel;

  rtc_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_32k_i),
    .hold_i (stop_i),
    .clr_i  (sec_wr),
    .tick_o (tick_1hz)
  );

  // one deferred step kept while the host window is open
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (sec_wr)     pend_q <= 1'b0;
    else if (acc_open_i) pend_q <= pend_q | tick_1hz;
    else                 pend_q <= 1'b0;
  end

  assign sec_adv = !acc_open_i && (tick_1hz || pend_q);

  rtc_bcd_reg #(.LIMIT(8'h59), .MASK(8'h7F), .LEAP(1'b1)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sec_adv), .we_i(sec_wr),
    .wdata_i(wdata_i), .val_o(sec_q), .carry_o(sec_c)
  );

  rtc_bcd_reg #(.LIMIT(8'h59), .MASK(8'h7F), .LEAP(1'b0)) u_min (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sec_c), .we_i(min_wr),
    .wdata_i(wdata_i), .val_o(min_q), .carry_o(min_c)
  );

  rtc_bcd_reg #(.LIMIT(8'h23), .MASK(8'h3F), .LEAP(1'b0)) u_hour (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(min_c), .we_i(hour_wr),
    .wdata_i(wdata_i), .val_o(hour_q), .carry_o(hour_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) day_carry_q <= 1'b0;
    else         day_carry_q <= hour_c;
  end

  assign day_carry_o = day_carry_q;

  always_comb begin
    rdata_o = 8'h00;
    if (sec_sel)       rdata_o = sec_q;
    else if (min_sel)  rdata_o = min_q;
    else if (hour_sel) rdata_o = hour_q;
  end
endmodule

// File: rtl/rtc_time_core_chk.sv
module rtc_time_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_i,
  input logic       acc_open_i,
  input logic       wr_en_i,
  input logic       sec_wr,
  input logic       pend_q,
  input logic       sec_adv,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic       day_carry_o
);
  assert_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_open_i && !wr_en_i |=> $stable(sec_q) && $stable(min_q) && $stable(hour_q));

  assert_halt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !pend_q && !wr_en_i |=> $stable(sec_q) && $stable(min_q) && $stable(hour_q));

  assert_sec_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_adv && !sec_wr && sec_q == 8'h59 |=> sec_q == 8'h00);

  assert_leap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_adv && !sec_wr && sec_q == 8'h60 |=> sec_q == 8'h00);

  assert_day_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_carry_o |=> !day_carry_o);

  assert_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_q[7] && !min_q[7] && hour_q[7:6] == 2'b00);
endmodule

bind rtc_time_core rtc_time_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_i(stop_i), .acc_open_i(acc_open_i),
  .wr_en_i(wr_en_i), .sec_wr(sec_wr), .pend_q(pend_q), .sec_adv(sec_adv),
  .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .day_carry_o(day_carry_o)
);

// File: tb/tb_rtc_time_core.sv
module tb_rtc_time_core;
  localparam int DIV_W = 4;
  localparam int DIVN  = 1 << DIV_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_tick = 1'b0, b_stop = 1'b1, b_acc = 1'b0, b_we = 1'b0;
  logic [7:0] b_addr = 8'h10, b_wdata = 8'h00;
  logic [7:0] rdata;
  logic day_carry;

  int errors = 0, checks = 0, dc_cnt = 0, rot = 0;
  bit half = 0, done = 0;
  string cur_req = "R1";

  // reference model state
  int m_sec = 0, m_min = 0, m_hour = 0, m_div = 0;
  bit m_pend = 0, m_dc = 0;

  always #4 clk = ~clk;

  rtc_time_core #(.DIV_W(DIV_W), .ADDR_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_32k_i(b_tick), .stop_i(b_stop),
    .acc_open_i(b_acc), .wr_en_i(b_we), .addr_i(b_addr), .wdata_i(b_wdata),
    .rdata_o(rdata), .day_carry_o(day_carry)
  );

  function automatic int to_bcd(int x); return ((x / 10) << 4) | (x % 10); endfunction
  function automatic int from_bcd(int v); return ((v >> 4) & 15) * 10 + (v & 15); endfunction

  always @(posedge clk) if (rst_n) begin
    bit secwr, tick, adv, cs, cm, ch;
    secwr = b_we && b_addr == 8'h10;
    tick  = b_tick && !b_stop && !secwr && m_div == DIVN - 1;
    if (b_stop || secwr) m_div = 0;
    else if (b_tick)     m_div = (m_div + 1) % DIVN;
    adv = !b_acc && (tick || m_pend);
    if (secwr)      m_pend = 0;
    else if (b_acc) m_pend = m_pend || tick;
    else            m_pend = 0;
    cs = adv && m_sec >= 59;
    cm = cs && m_min == 59;
    ch = cm && m_hour == 23;
    m_dc = ch;
    if (secwr) m_sec = from_bcd(b_wdata & 8'h7F);
    else if (adv) m_sec = cs ? 0 : m_sec + 1;
    if (b_we && b_addr == 8'h11) m_min = from_bcd(b_wdata & 8'h7F);
    else if (cs) m_min = cm ? 0 : m_min + 1;
    if (b_we && b_addr == 8'h12) m_hour = from_bcd(b_wdata & 8'h3F);
    else if (cm) m_hour = ch ? 0 : m_hour + 1;
  end

  task automatic check(string req, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int exp_rd(logic [7:0] a);
    case (a)
      8'h10:   return to_bcd(m_sec);
      8'h11:   return to_bcd(m_min);
      8'h12:   return to_bcd(m_hour);
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    check(cur_req, rdata, exp_rd(b_addr));
    check(cur_req, day_carry, m_dc);
    if (day_carry) dc_cnt++;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      if (half) b_tick = ~b_tick;
      if (!b_we) begin
        b_addr = 8'h10 + 8'(rot % 4);
        rot++;
      end
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    compare();
    b_we = 1'b1; b_addr = a; b_wdata = d;
    @(negedge clk);
    compare();
    b_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string req, int exp);
    b_addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h10, "R1", 8'h00);
    rd(8'h11, "R1", 8'h00);
    rd(8'h12, "R1", 8'h00);
    check("R1", day_carry, 0);

    // R2 full rate then half rate
    cur_req = "R2";
    b_stop = 1'b0; b_tick = 1'b1;
    cyc(DIVN);
    rd(8'h10, "R2", 8'h01);
    half = 1;
    cyc(2 * DIVN);
    rd(8'h10, "R2", 8'h02);
    half = 0; b_tick = 1'b1;

    // R3 R4 R5 full rollover
    cur_req = "R4";
    b_stop = 1'b1;
    wr(8'h12, 8'h23);
    wr(8'h11, 8'h59);
    wr(8'h10, 8'h58);
    dc_cnt = 0;
    b_stop = 1'b0;
    cyc(2 * DIVN + 8);
    rd(8'h10, "R3", 8'h00);
    rd(8'h11, "R4", 8'h00);
    rd(8'h12, "R4", 8'h00);
    check("R5", dc_cnt, 1);

    // R6 halt and restart
    cur_req = "R6";
    b_stop = 1'b1;
    cyc(30);
    rd(8'h10, "R6", 8'h00);
    b_stop = 1'b0;
    cyc(DIVN - 1);
    rd(8'h10, "R6", 8'h00);
    cyc(1);
    rd(8'h10, "R6", 8'h01);

    // R7 seconds write restarts divider
    cur_req = "R7";
    cyc(5);
    wr(8'h10, 8'h30);
    cyc(DIVN - 1);
    rd(8'h10, "R7", 8'h30);
    cyc(1);
    rd(8'h10, "R7", 8'h31);

    // R8 leap second
    cur_req = "R8";
    b_stop = 1'b1;
    wr(8'h10, 8'h60);
    wr(8'h11, 8'h10);
    rd(8'h10, "R8", 8'h60);
    b_stop = 1'b0;
    cyc(DIVN);
    rd(8'h10, "R8", 8'h00);
    rd(8'h11, "R8", 8'h11);

    // R9 step inside access window is deferred
    cur_req = "R9";
    b_stop = 1'b1;
    wr(8'h10, 8'h05);
    b_acc = 1'b1; b_stop = 1'b0;
    cyc(DIVN + 4);
    rd(8'h10, "R9", 8'h05);
    b_acc = 1'b0;
    cyc(1);
    rd(8'h10, "R9", 8'h06);

    // R11 masking, R10 map
    cur_req = "R11";
    b_stop = 1'b1;
    wr(8'h10, 8'hA5);
    rd(8'h10, "R11", 8'h25);
    wr(8'h11, 8'hD7);
    rd(8'h11, "R11", 8'h57);
    wr(8'h12, 8'hC3);
    rd(8'h12, "R11", 8'h03);
    cur_req = "R10";
    wr(8'h13, 8'h44);
    rd(8'h13, "R10", 8'h00);
    rd(8'h10, "R10", 8'h25);
    rd(8'h11, "R10", 8'h57);
    rd(8'h12, "R10", 8'h03);
    cyc(5);

    done = 1;
    summary();
    $finish;
  end
endmodule